// File: doc/BRIEF.md
# Tag-Ordered Merging Switch

A two-input, two-output switch for one stage of a multistage interconnect that keeps logical time. Time is counted in pulses. Within a pulse the switch forwards messages in ascending order of their tag, where the tag is the pair (source id, issue rank) compared with the source id as the more significant part. Neighbouring stages stay loosely in step by exchanging tokens. The switch sends a token on both outputs, then waits until a token has come back in on each input before it sends the next one. Every input and output is a valid/ready stream, and each flit carries a route bit, a tag, a ghost flag, a token flag and a payload byte.

A real message can leave only when it is known to be the smallest tag still to come in the current pulse. A single comparison per cycle chooses between the two input heads. An empty input blocks the choice unless a lower bound is known for it. A bound comes from a ghost (a null message carrying only a tag) or from the last message already taken from that input. When a real message goes out on one output, a ghost with the same tag goes out on the other output, as long as that output has no real traffic waiting. Ghosts sitting in an output slot give way to newer traffic. An incoming token may travel as a standalone flit or as a flag on the last message of the pulse.

Top module: `tag_merge_switch`

## Requirements
- R1: While reset is held the pulse count is 0, both outputs are invalid and both inputs are not ready. In the first cycle after reset both outputs present a standalone token flit (value 3), and the pulse count reads 1.
- R2: The pulse count rises by exactly one with each token wave and changes at no other time.
- R3: After the first wave, a new wave goes out only once a token has been taken on both inputs since the previous wave. An input that has delivered its token holds ready low until the next wave.
- R4: Among the competing input heads, the flit with the lowest 12-bit tag is taken, where the tag is {pid, rank}. On equal tags input 0 wins. A standalone token ranks above every tag.
- R5: If an input still owing its token is empty and no lower bound is known for it, nothing is taken from either input.
- R6: At most one input flit is accepted per cycle, and none is accepted in a cycle that emits a token wave.
- R7: When a real message is forwarded, the other output is loaded with a ghost of the same tag, its route bit set to that output's index and its payload zero, provided that output is empty, draining, or holding only a ghost.
- R8: A ghost held in an output slot may be replaced by a newer flit. A real message or token held while ready is low stays valid and unchanged.
- R9: A message whose token flag is set is forwarded with the token flag cleared and counts as that input's token for the pulse.
- R10: An arriving ghost is accepted and discarded, and its tag becomes the input's lower bound. A forwarded message's tag also becomes the bound. Bounds are cleared at each wave.
- R11: A real message leaves on output 0 when its route bit is 0, and on output 1 when it is 1.
- R12: Flit layout: bit 0 is the token flag, bit 1 the ghost flag, bit 2 the route bit, bits 6:3 the rank, bits 14:7 the pid and bits 22:15 the payload. Token=1 with ghost=1 is a standalone token. Ghost=1 alone is a ghost. Ghost=0 is a real message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 2 | Per-input flit valid |
| in_ready_o | output | 2 | Per-input flit accepted this cycle |
| in_flit_i | input | 2x23 | Per-input flit |
| out_valid_o | output | 2 | Per-output flit valid |
| out_ready_i | input | 2 | Per-output downstream ready |
| out_flit_o | output | 2x23 | Per-output flit |
| pulse_o | output | 16 | Current logical pulse count |

## Verification
Wrong token bookkeeping appears on `pulse_o` and as a missing or early token wave on both outputs. It also shows as an input whose ready stays low, or comes back too soon, within a cycle of the bad decision. A wrong bound or a wrong comparison shows in the very next cycle. Either the wrong flit appears in an output slot, or a ready is raised on an input that should have been blocked. Ghost handling and ghost overwrite errors show as a slot that should hold a ghost being empty, or a real flit vanishing while its ready was low. The reference model follows the slots every cycle, so all of these are caught in the cycle they happen.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  typedef enum logic [1:0] {HK_NONE, HK_MSG, HK_GHOST, HK_TOKEN} head_kind_e;

  localparam int unsigned TOK_BIT   = 0;
  localparam int unsigned GHOST_BIT = 1;
  localparam int unsigned ROUTE_BIT = 2;
  localparam int unsigned TAG_LSB   = 3;

  function automatic head_kind_e classify(logic vld, logic ghost, logic token);
    if (!vld)           return HK_NONE;
    if (ghost && token) return HK_TOKEN;
    if (ghost)          return HK_GHOST;
    return HK_MSG;
  endfunction
endpackage

// File: rtl/tsw_in_track.sv
module tsw_in_track
  import tsw_pkg::*;
#(
  parameter int unsigned TAG_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             new_pulse_i,
  input  logic             accept_i,
  input  head_kind_e       kind_i,
  input  logic             tok_flag_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             tok_seen_o,
  output logic             lb_v_o,
  output logic [TAG_W-1:0] lb_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_seen_o <= 1'b0;
      lb_v_o     <= 1'b0;
      lb_o       <= '0;
    end else if (new_pulse_i) begin
      tok_seen_o <= 1'b0;
      lb_v_o     <= 1'b0;
    end else if (accept_i) begin
      unique case (kind_i)
        HK_TOKEN: tok_seen_o <= 1'b1;
        HK_GHOST: begin
          lb_o   <= tag_i;
          lb_v_o <= 1'b1;
        end
        HK_MSG: begin
          lb_o   <= tag_i;
          lb_v_o <= 1'b1;
          if (tok_flag_i) tok_seen_o <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R10
  bound_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && !new_pulse_i && kind_i == HK_GHOST |=> lb_v_o && lb_o == $past(tag_i));

  // R3
  token_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_seen_o && !new_pulse_i |=> tok_seen_o);
endmodule

// File: rtl/tsw_pick.sv
module tsw_pick
  import tsw_pkg::*;
#(
  parameter int unsigned TAG_W = 12
) (
  input  logic [1:0]            active_i,
  input  head_kind_e [1:0]      kind_i,
  input  logic [1:0][TAG_W-1:0] tag_i,
  input  logic [1:0]            lb_v_i,
  input  logic [1:0][TAG_W-1:0] lb_i,
  output logic                  take_v_o,
  output logic                  take_idx_o
);
  localparam int unsigned KEY_W = TAG_W + 1;

  logic [1:0]            head, unknown;
  logic [1:0][KEY_W-1:0] key;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      head[i]    = active_i[i] && kind_i[i] != HK_NONE;
      unknown[i] = active_i[i] && kind_i[i] == HK_NONE && !lb_v_i[i];
      if (kind_i[i] == HK_TOKEN)     key[i] = '1;
      else if (kind_i[i] != HK_NONE) key[i] = {1'b0, tag_i[i]};
      else                           key[i] = {1'b0, lb_i[i]};
    end
  end

  // one comparison per cycle; equal keys favour input 0
  always_comb begin
    take_v_o   = 1'b0;
    take_idx_o = 1'b0;
    if (unknown == 2'b00) begin
      if (head[0] && (!active_i[1] || key[0] <= key[1])) begin
        take_v_o = 1'b1;
      end else if (head[1] && (!active_i[0] ||
                   (head[0] ? key[1] < key[0] : key[1] <= key[0]))) begin
        take_v_o   = 1'b1;
        take_idx_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsw_out_slot.sv
module tsw_out_slot
  import tsw_pkg::*;
#(
  parameter int unsigned FLIT_W = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [FLIT_W-1:0] load_flit_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [FLIT_W-1:0] flit_o,
  output logic              free_o
);
  logic held_ghost;
  assign held_ghost = flit_o[GHOST_BIT] && !flit_o[TOK_BIT];
  assign free_o     = !valid_o || ready_i || held_ghost;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      flit_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      flit_o  <= load_flit_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R8
  real_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && !held_ghost |=> valid_o && $stable(flit_o));
endmodule

// File: rtl/tag_merge_switch.sv
module tag_merge_switch
  import tsw_pkg::*;
#(
  parameter int unsigned PID_W   = 8,
  parameter int unsigned RANK_W  = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PULSE_W = 16,
  localparam int unsigned TAG_W  = PID_W + RANK_W,
  localparam int unsigned FLIT_W = DATA_W + TAG_W + 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              in_valid_i,
  output logic [1:0]              in_ready_o,
  input  logic [1:0][FLIT_W-1:0]  in_flit_i,
  output logic [1:0]              out_valid_o,
  input  logic [1:0]              out_ready_i,
  output logic [1:0][FLIT_W-1:0]  out_flit_o,
  output logic [PULSE_W-1:0]      pulse_o
);
  localparam logic [FLIT_W-1:0] TOKEN_FLIT = FLIT_W'((1 << TOK_BIT) | (1 << GHOST_BIT));

  head_kind_e [1:0]      kind;
  logic [1:0][TAG_W-1:0] tag, lb;
  logic [1:0]            tok_seen, lb_v, active, acc_in, slot_free, slot_load;
  logic [1:0][FLIT_W-1:0] slot_flit;
  logic                  first_q, take_v, take_idx, wave_go, accept, fwd, dest;
  logic [PULSE_W-1:0]    pulse_q;
  logic [FLIT_W-1:0]     sel, fwd_flit;

  for (genvar i = 0; i < 2; i++) begin : g_in
    assign kind[i]   = classify(in_valid_i[i], in_flit_i[i][GHOST_BIT], in_flit_i[i][TOK_BIT]);
    assign tag[i]    = in_flit_i[i][TAG_LSB +: TAG_W];
    assign active[i] = !tok_seen[i];
    assign acc_in[i] = accept && (take_idx == 1'(i));

    tsw_in_track #(.TAG_W(TAG_W)) u_track (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .new_pulse_i(wave_go),
      .accept_i   (acc_in[i]),
      .kind_i     (kind[i]),
      .tok_flag_i (in_flit_i[i][TOK_BIT]),
      .tag_i      (tag[i]),
      .tok_seen_o (tok_seen[i]),
      .lb_v_o     (lb_v[i]),
      .lb_o       (lb[i])
    );
  end

  tsw_pick #(.TAG_W(TAG_W)) u_pick (
    .active_i  (active),
    .kind_i    (kind),
    .tag_i     (tag),
    .lb_v_i    (lb_v),
    .lb_i      (lb),
    .take_v_o  (take_v),
    .take_idx_o(take_idx)
  );

  assign sel      = in_flit_i[take_idx];
  assign dest     = sel[ROUTE_BIT];
  assign wave_go  = (first_q || (&tok_seen)) && (&slot_free);
  assign accept   = take_v && !wave_go && (kind[take_idx] != HK_MSG || slot_free[dest]);
  assign fwd      = accept && kind[take_idx] == HK_MSG;
  assign in_ready_o = acc_in;

  always_comb begin
    fwd_flit          = sel;
    fwd_flit[TOK_BIT] = 1'b0;
  end

  for (genvar o = 0; o < 2; o++) begin : g_out
    logic [FLIT_W-1:0] ghost_flit;
    always_comb begin
      ghost_flit                      = '0;
      ghost_flit[TAG_LSB +: TAG_W]    = tag[take_idx];
      ghost_flit[GHOST_BIT]           = 1'b1;
      ghost_flit[ROUTE_BIT]           = 1'(o);
      slot_load[o] = 1'b0;
      slot_flit[o] = TOKEN_FLIT;
      if (wave_go) begin
        slot_load[o] = 1'b1;
      end else if (fwd && dest == 1'(o)) begin
        slot_load[o] = 1'b1;
        slot_flit[o] = fwd_flit;
      end else if (fwd && slot_free[o]) begin
        slot_load[o] = 1'b1;
        slot_flit[o] = ghost_flit;
      end
    end

    tsw_out_slot #(.FLIT_W(FLIT_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (slot_load[o]),
      .load_flit_i(slot_flit[o]),
      .ready_i    (out_ready_i[o]),
      .valid_o    (out_valid_o[o]),
      .flit_o     (out_flit_o[o]),
      .free_o     (slot_free[o])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      pulse_q <= '0;
    end else if (wave_go) begin
      first_q <= 1'b0;
      pulse_q <= pulse_q + 1'b1;
    end
  end
  assign pulse_o = pulse_q;

  // ordering monitor state for the checks below
  logic             last_v_q;
  logic [TAG_W-1:0] last_tag_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_v_q   <= 1'b0;
      last_tag_q <= '0;
    end else if (wave_go) begin
      last_v_q <= 1'b0;
    end else if (fwd) begin
      last_v_q   <= 1'b1;
      last_tag_q <= tag[take_idx];
    end
  end

  // R6
  one_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o[0] && in_ready_o[1]));

  // R2
  pulse_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q != $past(pulse_q) |-> pulse_q == PULSE_W'($past(pulse_q) + 1'b1));

  // R3
  wave_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q != $past(pulse_q) && $past(pulse_q) != '0 |-> $past(tok_seen) == 2'b11);

  // R4
  fwd_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd && last_v_q |-> tag[take_idx] >= last_tag_q);

  // R5
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tok_seen[0] && !in_valid_i[0] && !lb_v[0] |-> in_ready_o == 2'b00);
endmodule

// File: tb/tag_merge_switch_bench.sv
module tag_merge_switch_bench;
  localparam int PULSE_W = 16;
  localparam int FW      = 23;
  localparam int NP      = 60;
  localparam int INF_KEY = 99999;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]         in_valid, in_ready, out_valid, out_ready;
  logic [1:0][FW-1:0] in_flit, out_flit;
  logic [PULSE_W-1:0] pulse;

  tag_merge_switch u_tag_merge_switch (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .in_ready_o (in_ready),
    .in_flit_i  (in_flit),
    .out_valid_o(out_valid),
    .out_ready_i(out_ready),
    .out_flit_o (out_flit),
    .pulse_o    (pulse)
  );

  int checks = 0;
  int fails  = 0;
  logic [FW-1:0] q0[$];
  logic [FW-1:0] q1[$];
  int exp_msg[2];
  int obs_msg[2];
  bit hold[2];

  int            m_pulse;
  bit            m_first;
  bit            m_tok[2];
  bit            m_lbv[2];
  int            m_lb[2];
  bit            m_sv[2];
  logic [FW-1:0] m_sd[2];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(int pid, int rank, int route, int ghost, int token, int data);
    return {8'(data), 8'(pid), 4'(rank), 1'(route), 1'(ghost), 1'(token)};
  endfunction

  function automatic int tagof(logic [FW-1:0] f);
    return int'(f[14:3]);
  endfunction

  // 0 none, 1 message, 2 ghost, 3 standalone token
  function automatic int kindof(logic v, logic [FW-1:0] f);
    if (!v) return 0;
    if (f[1] && f[0]) return 3;
    if (f[1]) return 2;
    return 1;
  endfunction

  task automatic push(int i, logic [FW-1:0] f);
    if (i == 0) q0.push_back(f); else q1.push_back(f);
  endtask

  task automatic gen_pulse(bit tie);
    for (int i = 0; i < 2; i++) begin
      int n;
      int t;
      bit pig;
      n   = tie ? 3 : $urandom_range(0, 5);
      t   = tie ? 100 : $urandom_range(0, 3900);
      pig = n > 0 && $urandom_range(0, 1) == 1;
      for (int k = 0; k < n; k++) begin
        bit g;
        int r;
        bit tk;
        t += tie ? 7 : $urandom_range(1, 16);
        g  = !tie && k < n - 1 && $urandom_range(0, 4) == 0;
        r  = tie ? (i + k) % 2 : $urandom_range(0, 1);
        tk = pig && k == n - 1;
        push(i, mk(t >> 4, t & 15, r, g, tk, $urandom_range(0, 255)));
        if (!g) exp_msg[r]++;
      end
      if (!pig) push(i, mk(0, 0, 0, 1, 1, 0));
    end
  endtask

  task automatic step();
    int  kd[2], key[2];
    bit  act[2], head[2], unk[2], free[2];
    bit  wave, take, acc, idx;
    int  er[2];
    for (int i = 0; i < 2; i++) begin
      int qs;
      qs = (i == 0) ? q0.size() : q1.size();
      if (!hold[i] && qs > 0 && $urandom_range(0, 9) < 7) hold[i] = 1;
      in_valid[i] = hold[i];
      in_flit[i]  = hold[i] ? ((i == 0) ? q0[0] : q1[0]) : '0;
    end
    for (int o = 0; o < 2; o++) out_ready[o] = $urandom_range(0, 3) != 0;
    #1;
    for (int i = 0; i < 2; i++) begin
      act[i]  = !m_tok[i];
      kd[i]   = kindof(in_valid[i], in_flit[i]);
      head[i] = act[i] && kd[i] != 0;
      unk[i]  = act[i] && kd[i] == 0 && !m_lbv[i];
      key[i]  = kd[i] == 3 ? INF_KEY : (kd[i] != 0 ? tagof(in_flit[i]) : m_lb[i]);
    end
    for (int o = 0; o < 2; o++)
      free[o] = !m_sv[o] || out_ready[o] || (m_sd[o][1] && !m_sd[o][0]);
    wave = (m_first || (m_tok[0] && m_tok[1])) && free[0] && free[1];
    take = 0; idx = 0;
    if (!unk[0] && !unk[1]) begin
      if (head[0] && (!act[1] || key[0] <= key[1])) take = 1;
      else if (head[1] && (!act[0] || (head[0] ? key[1] < key[0] : key[1] <= key[0]))) begin
        take = 1; idx = 1;
      end
    end
    acc = take && !wave && (kd[idx] != 1 || free[in_flit[idx][2]]);
    for (int i = 0; i < 2; i++) er[i] = (acc && idx == 1'(i)) ? 1 : 0;

    chk(pulse == PULSE_W'(m_pulse), "R2 R3", "pulse", pulse, m_pulse);
    for (int o = 0; o < 2; o++) begin
      chk(out_valid[o] == m_sv[o], "R1 R7 R8", "out_valid", out_valid[o], m_sv[o]);
      if (m_sv[o]) chk(out_flit[o] == m_sd[o], "R4 R9 R11 R12", "out_flit", out_flit[o], m_sd[o]);
    end
    for (int i = 0; i < 2; i++)
      chk(in_ready[i] == 1'(er[i]), "R5 R9 R10", "in_ready", in_ready[i], er[i]);
    chk(!(in_ready[0] && in_ready[1]), "R6", "dual accept", in_ready, 0);

    for (int o = 0; o < 2; o++)
      if (out_valid[o] && out_ready[o] && !out_flit[o][1]) obs_msg[o]++;

    for (int o = 0; o < 2; o++) if (m_sv[o] && out_ready[o]) m_sv[o] = 0;
    if (wave) begin
      for (int o = 0; o < 2; o++) begin
        m_sv[o] = 1; m_sd[o] = mk(0, 0, 0, 1, 1, 0);
        m_tok[o] = 0; m_lbv[o] = 0;
      end
      m_pulse++;
      m_first = 0;
    end else if (acc) begin
      logic [FW-1:0] f;
      int d;
      f = in_flit[idx];
      if (kd[idx] == 3) m_tok[idx] = 1;
      else begin
        m_lb[idx] = tagof(f); m_lbv[idx] = 1;
        if (kd[idx] == 1) begin
          if (f[0]) m_tok[idx] = 1;
          d = int'(f[2]);
          m_sv[d] = 1; m_sd[d] = f & ~FW'(1);
          if (free[1-d]) begin
            m_sv[1-d] = 1;
            m_sd[1-d] = mk(tagof(f) >> 4, tagof(f) & 15, 1 - d, 1, 0, 0);
          end
        end
      end
      if (idx == 0) void'(q0.pop_front()); else void'(q1.pop_front());
      hold[idx] = 0;
    end
  endtask

  initial begin
    int cyc;
    in_valid = '0; in_flit = '0; out_ready = '0;
    m_pulse = 0; m_first = 1;
    for (int i = 0; i < 2; i++) begin
      m_tok[i] = 0; m_lbv[i] = 0; m_lb[i] = 0; m_sv[i] = 0; m_sd[i] = '0;
      exp_msg[i] = 0; obs_msg[i] = 0; hold[i] = 0;
    end
    gen_pulse(1);
    for (int p = 1; p < NP; p++) gen_pulse(0);

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 2'b00, "R1", "reset out_valid", out_valid, 0);
    chk(pulse == '0, "R1", "reset pulse", pulse, 0);
    chk(in_ready == 2'b00, "R1", "reset in_ready", in_ready, 0);
    rst_n = 1'b1;

    cyc = 0;
    while ((q0.size() > 0 || q1.size() > 0 || hold[0] || hold[1]) && cyc < 150000) begin
      step();
      cyc++;
      @(negedge clk);
    end
    if (cyc >= 150000) chk(0, "R3", "watchdog expired", cyc, 0);
    repeat (40) begin
      step();
      @(negedge clk);
    end
    chk(pulse == PULSE_W'(NP + 1), "R2", "final pulse", pulse, NP + 1);
    for (int o = 0; o < 2; o++)
      chk(obs_msg[o] == exp_msg[o], "R11", "messages per output", obs_msg[o], exp_msg[o]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule